// File: doc/BRIEF.md
# Masked Share-Domain Logic Unit

This block performs bitwise logic on a secret bit that never exists in plain form. Each operand is held as a vector of M Boolean shares whose XOR is the secret value. The unit evaluates NOT, AND or XOR of two such sharings, or re-randomizes one sharing, and delivers the result as a new share vector. AND uses the pairwise cross-term construction that tolerates an attacker who probes up to T internal wires. With M = 2T+1 shares and one fresh random bit per share pair, no wire ever carries an unmasked operand or product.

A caller presents both operand sharings, a vector of fresh random bits from an external generator, an operation code and a valid strobe. One clock later the registered result appears with a single-cycle valid pulse. Operations can be issued on back-to-back cycles. The probing order T is a parameter, and every width is derived from it.

Top module: `share_logic_unit`

## Requirements
- R1: The share count is M = 2T+1 with T >= 1 a parameter, and the random input `rnd` is M(M-1)/2 bits wide. T < 1 is rejected at elaboration.
- R2: Operation code 0 (NOT) yields share 0 equal to the inverted share 0 of `a_sh` and every other share equal to the matching share of `a_sh`.
- R3: Operation code 1 (AND) yields shares whose XOR equals (XOR of `a_sh`) AND (XOR of `b_sh`) for any random input.
- R4: In AND, the random bit for share pair (i,j), i<j, is `rnd[k]`, where k counts pairs in row-major order (pair (0,1) is bit 0, then (0,2), ... (1,2), ...). When all products vanish (`a_sh` = 0), each result share i equals the XOR of the random bits of all pairs that contain i.
- R5: Operation code 2 (XOR) yields share i = `a_sh[i]` XOR `b_sh[i]`, whatever the value of `rnd`.
- R6: Operation code 3 (REFRESH) yields share i = `a_sh[i]` XOR `rnd[i-1]` for i >= 1, and share 0 = `a_sh[0]` XOR the XOR of `rnd[M-2:0]`. `b_sh` has no effect, and the encoded value is preserved.
- R7: `out_valid` is high in the cycle after each cycle in which `in_valid` was high, and is low otherwise. The result comes from the inputs present in that earlier cycle.
- R8: During and right after reset, `out_valid` is 0 and `c_sh` is all zeros.
- R9: While no operation is accepted, `c_sh` holds its last value regardless of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accepts an operation this cycle |
| op | input | 2 | 0 NOT, 1 AND, 2 XOR, 3 REFRESH |
| a_sh | input | M | Shares of operand a |
| b_sh | input | M | Shares of operand b |
| rnd | input | M(M-1)/2 | Fresh random bits, one per share pair |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| c_sh | output | M | Registered result shares |

## Verification
The recombination properties assume that `op`, `a_sh` and `b_sh` are known, non-X values whenever `in_valid` is high. They also assume that reset is released synchronously away from an accepted operation. The probing security of AND further assumes that `rnd` is fresh and uniform on every accepted operation, but no property checks this. The stimulus drives every input at the falling edge with fully defined values and draws a new `rnd` word for each operation. It sweeps every operation code and every operand sharing exhaustively at T=1, and randomly at T=2 and T=3.

// File: rtl/share_logic_pkg.sv
package share_logic_pkg;

   typedef enum logic [1:0] {
      OPC_NOT     = 2'd0,
      OPC_AND     = 2'd1,
      OPC_XOR     = 2'd2,
      OPC_REFRESH = 2'd3
   } share_op_e;

   // share count for a probing order
   function automatic int unsigned shares_for(input int unsigned order);
      return 2 * order + 1;
   endfunction

   // number of unordered share pairs
   function automatic int unsigned pairs_for(input int unsigned nsh);
      return (nsh * (nsh - 1)) / 2;
   endfunction

endpackage

// File: rtl/slu_linear.sv
module slu_linear #(
   parameter int unsigned M = 3
) (
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic [M-1:0] not_c,
   output logic [M-1:0] xor_c
);
   for (genvar i = 0; i < M; i++) begin : g_sh
      if (i == 0) begin : g_first
         assign not_c[i] = ~a[i];
      end else begin : g_rest
         assign not_c[i] = a[i];
      end
      assign xor_c[i] = a[i] ^ b[i];
   end
endmodule

// File: rtl/slu_refresh.sv
module slu_refresh #(
   parameter int unsigned M = 3
) (
   input  logic [M-1:0] a,
   input  logic [M-2:0] r,
   output logic [M-1:0] c
);
   logic r_sum;
   assign r_sum = ^r;
   assign c[0]  = a[0] ^ r_sum;
   for (genvar i = 1; i < M; i++) begin : g_mask
      assign c[i] = a[i] ^ r[i-1];
   end
endmodule

// File: rtl/slu_and_core.sv
module slu_and_core #(
   parameter int unsigned M  = 3,
   parameter int unsigned RW = (M * (M - 1)) / 2
) (
   input  logic [M-1:0]  a,
   input  logic [M-1:0]  b,
   input  logic [RW-1:0] z,
   output logic [M-1:0]  c
);
   // upper triangle: random pair bits; lower triangle: mirror terms plus diagonal product
   logic [M-1:0] zu [M];
   logic [M-1:0] zl [M];

   for (genvar i = 0; i < M; i++) begin : g_row
      for (genvar j = 0; j < M; j++) begin : g_col
         if (j > i) begin : g_up
            localparam int K = i * M - (i * (i + 1)) / 2 + (j - i - 1);
            assign zu[i][j] = z[K];
            assign zl[i][j] = 1'b0;
         end else if (j == i) begin : g_diag
            assign zu[i][j] = 1'b0;
            assign zl[i][j] = a[i] & b[i];
         end else begin : g_lo
            // mirror of pair (j,i): inner XOR is formed first
            assign zu[i][j] = 1'b0;
            assign zl[i][j] = (zu[j][i] ^ (a[j] & b[i])) ^ (a[i] & b[j]);
         end
      end
      assign c[i] = ^(zu[i] ^ zl[i]);
   end
endmodule

// File: rtl/share_logic_unit.sv
module share_logic_unit
   import share_logic_pkg::*;
#(
   parameter int unsigned T  = 1,
   parameter int unsigned M  = 2 * T + 1,
   parameter int unsigned RW = (M * (M - 1)) / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [1:0]    op,
   input  logic [M-1:0]  a_sh,
   input  logic [M-1:0]  b_sh,
   input  logic [RW-1:0] rnd,
   output logic          out_valid,
   output logic [M-1:0]  c_sh
);
   localparam int unsigned MX = shares_for(T);
   localparam int unsigned PX = pairs_for(MX);

   // R1: elaboration checks on the configuration
   if (T < 1) begin : g_bad_order
      $error("share_logic_unit: T must be at least 1");
   end
   if (M != MX) begin : g_bad_shares
      $error("share_logic_unit: M must equal 2T+1");
   end
   if (RW != PX) begin : g_bad_rnd
      $error("share_logic_unit: RW must equal M(M-1)/2");
   end

   logic [M-1:0] not_c, xor_c, and_c, ref_c;
   logic [M-1:0] res;
   logic [M-1:0] c_q;
   logic         v_q;

   slu_linear #(.M(M)) u_linear (
      .a     (a_sh),
      .b     (b_sh),
      .not_c (not_c),
      .xor_c (xor_c)
   );

   slu_and_core #(.M(M), .RW(RW)) u_and (
      .a (a_sh),
      .b (b_sh),
      .z (rnd),
      .c (and_c)
   );

   slu_refresh #(.M(M)) u_refresh (
      .a (a_sh),
      .r (rnd[M-2:0]),
      .c (ref_c)
   );

   always_comb begin
      unique case (share_op_e'(op))
         OPC_NOT:     res = not_c;
         OPC_AND:     res = and_c;
         OPC_XOR:     res = xor_c;
         default:     res = ref_c;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         c_q <= '0;
      end else begin
         v_q <= in_valid;
         if (in_valid) c_q <= res;
      end
   end

   assign out_valid = v_q;
   assign c_sh      = c_q;

   p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(c_sh));
   p_not_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'd0) |=> (c_sh == ($past(a_sh) ^ M'(1))));
   p_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'd1) |=> ((^c_sh) == ($past(^a_sh) & $past(^b_sh))));
   p_xor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'd2) |=> (c_sh == ($past(a_sh) ^ $past(b_sh))));
   p_refresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 2'd3) |=> ((^c_sh) == $past(^a_sh)));
endmodule

// File: tb/share_logic_unit_bench.sv
module share_logic_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [6:0]  a_all = '0;
   logic [6:0]  b_all = '0;
   logic [20:0] r_all = '0;
   logic [6:0]  c_all [3];
   logic        ov    [3];
   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   for (genvar g = 1; g <= 3; g++) begin : g_inst
      localparam int M  = 2 * g + 1;
      localparam int RW = (M * (M - 1)) / 2;
      logic [M-1:0] c_w;
      logic         v_w;
      share_logic_unit #(.T(g)) u_share_logic_unit (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (in_valid),
         .op        (op),
         .a_sh      (a_all[M-1:0]),
         .b_sh      (b_all[M-1:0]),
         .rnd       (r_all[RW-1:0]),
         .out_valid (v_w),
         .c_sh      (c_w)
      );
      assign c_all[g-1] = 7'(c_w);
      assign ov[g-1]    = v_w;
   end

   task automatic chk(input string req, input logic [20:0] act, input logic [20:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] msk(input int m);
      return 7'((1 << m) - 1);
   endfunction

   function automatic logic par(input logic [6:0] v, input int m);
      return ^(v & msk(m));
   endfunction

   // expected exact shares for NOT, XOR, REFRESH, and AND with a zero a
   function automatic logic [6:0] exact(input logic [1:0] o, input logic [6:0] a,
                                        input logic [6:0] b, input logic [20:0] r, input int m);
      logic [6:0] s;
      logic acc;
      int k;
      s = '0;
      case (o)
         2'd0: s = (a ^ 7'd1) & msk(m);
         2'd2: s = (a ^ b) & msk(m);
         2'd3: begin
            s = a & msk(m);
            acc = 1'b0;
            for (int i = 1; i < m; i++) begin
               s[i] = s[i] ^ r[i-1];
               acc  = acc ^ r[i-1];
            end
            s[0] = s[0] ^ acc;
         end
         default: begin
            k = 0;
            for (int i = 0; i < m; i++)
               for (int j = i + 1; j < m; j++) begin
                  s[i] = s[i] ^ r[k];
                  s[j] = s[j] ^ r[k];
                  k++;
               end
         end
      endcase
      return s;
   endfunction

   task automatic check_all(input logic [1:0] o);
      for (int g = 0; g < 3; g++) begin
         int m;
         logic e;
         m = 2 * g + 3;
         chk("R7 valid pulse", 21'(ov[g]), 21'd1);
         case (o)
            2'd0: e = ~par(a_all, m);
            2'd1: e = par(a_all, m) & par(b_all, m);
            2'd2: e = par(a_all, m) ^ par(b_all, m);
            default: e = par(a_all, m);
         endcase
         chk("R3 R6 recombined value", 21'(par(c_all[g], m)), 21'(e));
         if (o == 2'd0) chk("R2 NOT shares", 21'(c_all[g]), 21'(exact(o, a_all, b_all, r_all, m)));
         if (o == 2'd2) chk("R5 XOR shares", 21'(c_all[g]), 21'(exact(o, a_all, b_all, r_all, m)));
         if (o == 2'd3) chk("R6 REFRESH shares", 21'(c_all[g]), 21'(exact(o, a_all, b_all, r_all, m)));
      end
   endtask

   initial begin
      logic [6:0] hold [3];
      repeat (3) @(negedge clk);
      for (int g = 0; g < 3; g++) begin
         chk("R8 reset valid", 21'(ov[g]), 21'd0);
         chk("R8 reset shares", 21'(c_all[g]), 21'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      for (int g = 0; g < 3; g++) chk("R8 after reset valid", 21'(ov[g]), 21'd0);

      // R1: widths follow 2T+1 and M(M-1)/2
      chk("R1 rnd width T3", 21'($bits(g_inst[3].u_share_logic_unit.rnd)), 21'd21);
      chk("R1 share width T2", 21'($bits(g_inst[2].u_share_logic_unit.a_sh)), 21'd5);

      // back-to-back sweep: exhaustive over op and 3-share operands
      for (int k = 0; k < 512; k++) begin
         logic [8:0] kk;
         kk = 9'(k);
         op       = kk[7:6];
         a_all    = {4'($urandom), kk[2:0]};
         b_all    = {4'($urandom), kk[5:3]};
         r_all    = 21'($urandom);
         in_valid = 1'b1;
         @(negedge clk);
         check_all(kk[7:6]);
      end

      // R4: pair bit mapping with a zero operand a
      for (int k = 0; k < 40; k++) begin
         op = 2'd1;
         a_all = '0;
         b_all = 7'($urandom);
         r_all = 21'($urandom);
         in_valid = 1'b1;
         @(negedge clk);
         for (int g = 0; g < 3; g++)
            chk("R4 AND pair mapping", 21'(c_all[g]),
                21'(exact(2'd1, a_all, b_all, r_all, 2 * g + 3)));
      end

      // R5: XOR ignores rnd
      op = 2'd2; a_all = 7'h5a; b_all = 7'h33; r_all = '0; in_valid = 1'b1;
      @(negedge clk);
      for (int g = 0; g < 3; g++) hold[g] = c_all[g];
      r_all = 21'h1fffff;
      @(negedge clk);
      for (int g = 0; g < 3; g++) chk("R5 rnd has no effect", 21'(c_all[g]), 21'(hold[g]));

      // R6: REFRESH ignores b
      op = 2'd3; a_all = 7'h2c; b_all = '0; r_all = 21'h0abcde;
      @(negedge clk);
      for (int g = 0; g < 3; g++) hold[g] = c_all[g];
      b_all = 7'h7f;
      @(negedge clk);
      for (int g = 0; g < 3; g++) chk("R6 b has no effect", 21'(c_all[g]), 21'(hold[g]));

      // R7/R9: idle cycles keep shares and drop valid
      in_valid = 1'b0;
      repeat (3) begin
         a_all = 7'($urandom); b_all = 7'($urandom); r_all = 21'($urandom);
         op = 2'($urandom);
         @(negedge clk);
         for (int g = 0; g < 3; g++) begin
            chk("R7 no valid when idle", 21'(ov[g]), 21'd0);
            chk("R9 shares held", 21'(c_all[g]), 21'(hold[g]));
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule